// File: doc/BRIEF.md
# Peripheral Clock Stop and Suspend Sequencer

This block holds the clock-stop mask for sixteen peripherals and the control and status word of the main PLL, and it runs the hardware half of a suspend and resume handshake. Each stop bit is active high: a set bit stops that peripheral's clock and a clear bit lets it run. The block exposes the result as one run-enable output per peripheral, which drives the clock gating cells. The PLL itself is modelled by a settle counter. The PLL stable flag rises a programmable number of reference cycles after the PLL is enabled, and it falls at once when the PLL is disabled.

A suspend request stops the timer, DMA and UART0 clocks and, one cycle later, turns the PLL off. A resume request turns the PLL on, waits for the stable flag, and only then restarts those three clocks. While either sequence is running, `busy_o` is high, new requests are dropped, and writes to the stop-mask and PLL words are dropped. A separate low-power word holds the bit that makes the wait state sleep rather than idle.

Software reaches the three words through a one-cycle write strobe and a combinational read mux. Word select codes are: 0 = clock-stop mask, 1 = PLL word, 2 = low-power word, 3 = unused (reads as zero, writes ignored).

Top module: `clk_stop_seq`

## Requirements
- R1: After reset:
  - every stop bit is clear, so `clk_run_o` = 16'hFFFF;
  - the PLL is enabled with bypass off and a settle field of 3, so the PLL word reads 0x103 until stable;
  - `busy_o` is 0 and `sleep_mode_o` is 0.
- R2: A write to word 0 while idle stores `wr_data_i[15:0]` as the stop mask. The mask reads back in bits 15:0. `clk_run_o` is its bitwise inverse from the following cycle.
- R3: The stop-mask bit positions are:
  - 0 UART0, 1 timer, 2 RTC, 3 I2C, 4 SPI, 5 audio controller, 6 I2S, 7 MMC;
  - 8 ADC, 9 camera, 10 LCD, 11 USB device, 12 DMA, 13 image unit, 14 USB host, 15 UART1.

  The suspend and resume sequences touch only bits 0, 1 and 12 (mask 0x1003), and they leave every other bit as it was.
- R4: A suspend request accepted at a clock edge sets bits 0x1003 at that edge. It clears the PLL enable at the next edge, and `busy_o` is high for exactly the one cycle in between.
- R5: A resume request accepted at edge E sets the PLL enable at E. Bits 0x1003 are cleared at the first edge that sees `pll_stable_o` high. `busy_o` stays high until that edge.
- R6: With settle field F, `pll_stable_o` rises at the (F+1)*SETTLE_SCALE-th edge after the edge that set the enable. It stays high while the enable is held. It drops in the same cycle the enable is cleared.
- R7: PLL word layout:
  - bits 3:0 are the settle field;
  - bit 8 is the enable;
  - bit 9 is the bypass, which drives `pll_bypass_o`;
  - bit 10 reads the stable flag and ignores writes.
- R8: Bit 0 of word 2 is the sleep select. It is written at any time and drives `sleep_mode_o`, where 1 = sleep and 0 = idle.
- R9: Suspend and resume requests that arrive while `busy_o` is high are ignored.
- R10: Writes to words 0 and 1 are dropped while `busy_o` is high and in the cycle a request is accepted. If both requests arrive together while idle, suspend is taken and resume is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Word select for writes |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Word select for reads |
| rd_data_o | output | 32 | Read data of the selected word |
| suspend_req_i | input | 1 | Suspend request, one-cycle pulse |
| resume_req_i | input | 1 | Resume request, one-cycle pulse |
| busy_o | output | 1 | A sequence is in progress |
| clk_run_o | output | 16 | Per-peripheral clock run enable |
| pll_en_o | output | 1 | PLL enable |
| pll_bypass_o | output | 1 | PLL bypass select |
| pll_stable_o | output | 1 | PLL stable indication |
| sleep_mode_o | output | 1 | Wait state is sleep (1) or idle (0) |

## Verification
The assertions assume the following about the block's inputs:
- request pulses are synchronous to `clk_i`;
- the settle field is not rewritten while the PLL is counting toward stable, so the rise of the flag follows the field that was present at enable time.

The stimulus keeps within these assumptions:
- settle fields are written only while the PLL is off or already stable;
- requests and writes are driven on the falling edge;
- random requests and writes are fired only in cycles where the bench knows whether the block is busy, so the expected register contents stay exact.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  localparam int DATA_W = 32;
  localparam int GATE_W = 16;
  localparam int STAB_W = 4;

  localparam int PLL_EN_BIT  = 8;
  localparam int PLL_BYP_BIT = 9;
  localparam int PLL_STB_BIT = 10;

  localparam int GB_UART0 = 0;
  localparam int GB_TIMER = 1;
  localparam int GB_DMA   = 12;

  localparam logic [GATE_W-1:0] SUSPEND_MASK =
    GATE_W'((1 << GB_UART0) | (1 << GB_TIMER) | (1 << GB_DMA));

  typedef enum logic [1:0] {
    SEL_GATE = 2'd0,
    SEL_PLL  = 2'd1,
    SEL_LPWR = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE     = 2'd0,
    SQ_SUSP_PLL = 2'd1,
    SQ_RES_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/clk_stop_settle.sv
module clk_stop_settle
  import clk_stop_pkg::*;
#(
  parameter int SCALE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [STAB_W-1:0] stab_i,
  output logic              stable_o
);
  localparam int MAX_T = (1 << STAB_W) * SCALE;
  localparam int CNT_W = $clog2(MAX_T) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;
  logic             stable_q;

  assign target = CNT_W'((32'(stab_i) + 32'd1) * 32'(SCALE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!stable_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q >= target - 1'b1) stable_q <= 1'b1;
    end
  end

  // flag falls combinationally with enable
  assign stable_o = stable_q & en_i;

  assert_stable_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stable_q && en_i) |=> stable_q);
  assert_stable_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !stable_q);
endmodule

// File: rtl/clk_stop_fsm.sv
module clk_stop_fsm
  import clk_stop_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic suspend_req_i,
  input  logic resume_req_i,
  input  logic pll_stable_i,
  output logic stop_set_o,
  output logic pll_off_o,
  output logic pll_on_o,
  output logic stop_clr_o,
  output logic busy_o
);
  seq_state_e state_q, state_d;

  assign stop_set_o = (state_q == SQ_IDLE) && suspend_req_i;
  assign pll_on_o   = (state_q == SQ_IDLE) && !suspend_req_i && resume_req_i;
  assign pll_off_o  = (state_q == SQ_SUSP_PLL);
  assign stop_clr_o = (state_q == SQ_RES_WAIT) && pll_stable_i;
  assign busy_o     = (state_q != SQ_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (stop_set_o)    state_d = SQ_SUSP_PLL;
        else if (pll_on_o) state_d = SQ_RES_WAIT;
      end
      SQ_SUSP_PLL: state_d = SQ_IDLE;
      SQ_RES_WAIT: if (pll_stable_i) state_d = SQ_IDLE;
      default:     state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SQ_IDLE;
    else         state_q <= state_d;
  end

  assert_susp_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_SUSP_PLL) |=> (state_q == SQ_IDLE));
  assert_wait_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_RES_WAIT && !pll_stable_i) |=> (state_q == SQ_RES_WAIT));
endmodule

// File: rtl/clk_stop_regs.sv
module clk_stop_regs
  import clk_stop_pkg::*;
#(
  parameter logic [STAB_W-1:0] STAB_RESET = 4'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stop_set_i,
  input  logic              stop_clr_i,
  input  logic              pll_on_i,
  input  logic              pll_off_i,
  input  logic              busy_i,
  output logic [GATE_W-1:0] stop_q_o,
  output logic              pll_en_o,
  output logic              pll_byp_o,
  output logic [STAB_W-1:0] stab_o,
  output logic              sleep_o
);
  logic block_wr;
  logic wr_stop, wr_pll, wr_lp;
  logic unused_wr;

  assign block_wr = busy_i | stop_set_i | pll_on_i;
  assign wr_stop  = wr_en_i && (wr_sel_i == SEL_GATE) && !block_wr;
  assign wr_pll   = wr_en_i && (wr_sel_i == SEL_PLL) && !block_wr;
  assign wr_lp    = wr_en_i && (wr_sel_i == SEL_LPWR);
  assign unused_wr = ^wr_data_i[DATA_W-1:GATE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q_o <= '0;
    end else if (stop_set_i) begin
      stop_q_o <= stop_q_o | SUSPEND_MASK;
    end else if (stop_clr_i) begin
      stop_q_o <= stop_q_o & ~SUSPEND_MASK;
    end else if (wr_stop) begin
      stop_q_o <= wr_data_i[GATE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_en_o  <= 1'b1;
      pll_byp_o <= 1'b0;
      stab_o    <= STAB_RESET;
    end else if (pll_off_i) begin
      pll_en_o <= 1'b0;
    end else if (pll_on_i) begin
      pll_en_o <= 1'b1;
    end else if (wr_pll) begin
      pll_en_o  <= wr_data_i[PLL_EN_BIT];
      pll_byp_o <= wr_data_i[PLL_BYP_BIT];
      stab_o    <= wr_data_i[STAB_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sleep_o <= 1'b0;
    else if (wr_lp) sleep_o <= wr_data_i[0];
  end

  assert_suspend_stops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_set_i |=> ((stop_q_o & SUSPEND_MASK) == SUSPEND_MASK));
  assert_resume_enables_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_on_i |=> pll_en_o);
  assert_busy_write_dropped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_GATE && busy_i && !stop_clr_i) |=> $stable(stop_q_o));
endmodule

// File: rtl/clk_stop_seq.sv
module clk_stop_seq
  import clk_stop_pkg::*;
#(
  parameter int                SETTLE_SCALE = 4,
  parameter logic [STAB_W-1:0] STAB_RESET   = 4'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              suspend_req_i,
  input  logic              resume_req_i,
  output logic              busy_o,
  output logic [GATE_W-1:0] clk_run_o,
  output logic              pll_en_o,
  output logic              pll_bypass_o,
  output logic              pll_stable_o,
  output logic              sleep_mode_o
);
  logic              stop_set, stop_clr, pll_on, pll_off;
  logic [GATE_W-1:0] stop_q;
  logic [STAB_W-1:0] stab;

  clk_stop_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .suspend_req_i(suspend_req_i),
    .resume_req_i (resume_req_i),
    .pll_stable_i (pll_stable_o),
    .stop_set_o   (stop_set),
    .pll_off_o    (pll_off),
    .pll_on_o     (pll_on),
    .stop_clr_o   (stop_clr),
    .busy_o       (busy_o)
  );

  clk_stop_regs #(.STAB_RESET(STAB_RESET)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .stop_set_i(stop_set),
    .stop_clr_i(stop_clr),
    .pll_on_i  (pll_on),
    .pll_off_i (pll_off),
    .busy_i    (busy_o),
    .stop_q_o  (stop_q),
    .pll_en_o  (pll_en_o),
    .pll_byp_o (pll_bypass_o),
    .stab_o    (stab),
    .sleep_o   (sleep_mode_o)
  );

  clk_stop_settle #(.SCALE(SETTLE_SCALE)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (pll_en_o),
    .stab_i  (stab),
    .stable_o(pll_stable_o)
  );

  assign clk_run_o = ~stop_q;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_sel_i)
      SEL_GATE: rd_data_o[GATE_W-1:0] = stop_q;
      SEL_PLL: begin
        rd_data_o[STAB_W-1:0]  = stab;
        rd_data_o[PLL_EN_BIT]  = pll_en_o;
        rd_data_o[PLL_BYP_BIT] = pll_bypass_o;
        rd_data_o[PLL_STB_BIT] = pll_stable_o;
      end
      SEL_LPWR: rd_data_o[0] = sleep_mode_o;
      default:  rd_data_o = '0;
    endcase
  end

  assert_ungate_after_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(clk_run_o[GB_DMA]) && $past(busy_o)) |-> $past(pll_stable_o));
  assert_pll_off_after_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_en_o) && $past(busy_o) |-> ((clk_run_o & SUSPEND_MASK) == '0));
endmodule

// File: tb/clk_stop_seq_test.sv
module clk_stop_seq_test;
  import clk_stop_pkg::*;

  localparam int SCALE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        sus_req = 1'b0;
  logic        res_req = 1'b0;
  logic        busy;
  logic [15:0] run;
  logic        pll_en, pll_byp, pll_stb, sleep;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clk_stop_seq #(.SETTLE_SCALE(SCALE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .suspend_req_i(sus_req), .resume_req_i(res_req), .busy_o(busy),
    .clk_run_o(run), .pll_en_o(pll_en), .pll_bypass_o(pll_byp),
    .pll_stable_o(pll_stb), .sleep_mode_o(sleep)
  );

  function automatic int settle_cycles(input logic [3:0] f);
    return (int'(f) + 1) * SCALE;
  endfunction

  function automatic logic [31:0] pll_word(input logic en, byp, stb, input logic [3:0] f);
    logic [31:0] w;
    w = '0;
    w[3:0] = f; w[8] = en; w[9] = byp; w[10] = stb;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive for one edge, return at following negedge
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    rd_sel = sel;
    #1 d = rd_data;
  endtask

  task automatic wait_stable();
    for (int i = 0; i < 100 && !pll_stb; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, g;
    logic [3:0]  f;
    int unsigned seed;
    seed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 run", {16'd0, run}, 32'h0000_FFFF);
    rd(SEL_GATE, d); chk("R1 mask", d, 32'd0);
    rd(SEL_PLL, d);  chk("R1 pll word", d, 32'h103);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 sleep", {31'd0, sleep}, 32'd0);
    rst_n = 1'b1;
    // R6 stable 16 edges after release
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k == 15) chk("R6 not yet stable", {31'd0, pll_stb}, 32'd0);
      if (k == 16) chk("R6 stable after reset", {31'd0, pll_stb}, 32'd1);
    end

    // R2 random mask writes
    for (int i = 0; i < 20; i++) begin
      d = $urandom;
      wr(SEL_GATE, d);
      rd(SEL_GATE, g);
      chk("R2 mask readback", g, {16'd0, d[15:0]});
      chk("R2 run inverse", {16'd0, run}, {16'd0, ~d[15:0]});
    end
    wr(SEL_GATE, 32'h0000_0000);

    // R7 layout, bit 10 read-only
    wr(SEL_PLL, pll_word(1'b1, 1'b1, 1'b0, 4'd2));
    rd(SEL_PLL, d);
    chk("R7 pll word stable kept", d, pll_word(1'b1, 1'b1, 1'b1, 4'd2));
    chk("R7 bypass pin", {31'd0, pll_byp}, 32'd1);
    wr(SEL_PLL, pll_word(1'b0, 1'b0, 1'b1, 4'd5));
    rd(SEL_PLL, d);
    chk("R7 stable not writable", d, pll_word(1'b0, 1'b0, 1'b0, 4'd5));
    chk("R6 drop with enable", {31'd0, pll_stb}, 32'd0);

    // R8 low-power select
    for (int i = 0; i < 4; i++) begin
      d = $urandom;
      wr(SEL_LPWR, d);
      chk("R8 sleep pin", {31'd0, sleep}, {31'd0, d[0]});
      rd(SEL_LPWR, g);
      chk("R8 readback", g, {31'd0, d[0]});
    end

    // suspend/resume rounds
    for (int r = 0; r < 6; r++) begin
      f = (r == 0) ? 4'd0 : (r == 1) ? 4'd15 : 4'($urandom);
      wr(SEL_PLL, pll_word(1'b1, 1'b0, 1'b0, 4'd1));
      wait_stable();
      g = {16'd0, 16'($urandom)};
      wr(SEL_GATE, g);
      // suspend, with a write and resume in its busy cycle
      @(negedge clk); sus_req = 1'b1;
      @(negedge clk); sus_req = 1'b0;
      chk("R3 suspend mask", {16'd0, run}, {16'd0, ~(g[15:0] | SUSPEND_MASK)});
      chk("R4 pll still on", {31'd0, pll_en}, 32'd1);
      chk("R4 busy", {31'd0, busy}, 32'd1);
      res_req = 1'b1; wr_en = 1'b1; wr_sel = SEL_GATE; wr_data = 32'hFFFF_FFFF;
      @(negedge clk);
      res_req = 1'b0; wr_en = 1'b0;
      chk("R4 pll off", {31'd0, pll_en}, 32'd0);
      chk("R9 resume ignored", {31'd0, busy}, 32'd0);
      rd(SEL_GATE, d);
      chk("R10 busy write dropped", d, g | {16'd0, SUSPEND_MASK});
      // set settle field while off
      wr(SEL_PLL, pll_word(1'b0, 1'b0, 1'b0, f));
      // resume
      @(negedge clk); res_req = 1'b1;
      @(negedge clk); res_req = 1'b0;
      chk("R5 pll on", {31'd0, pll_en}, 32'd1);
      for (int k = 1; k <= settle_cycles(f) + 1; k++) begin
        if (k == 1) sus_req = 1'b1;
        @(negedge clk);
        sus_req = 1'b0;
        if (k == settle_cycles(f) - 1)
          chk("R6 stable early", {31'd0, pll_stb}, 32'd0);
        if (k == settle_cycles(f)) begin
          chk("R6 stable on time", {31'd0, pll_stb}, 32'd1);
          chk("R5 still stopped", {16'd0, run & SUSPEND_MASK}, 32'd0);
          chk("R9 busy in wait", {31'd0, busy}, 32'd1);
        end
        if (k == settle_cycles(f) + 1) begin
          chk("R5 restarted", {16'd0, run}, {16'd0, ~(g[15:0] & ~SUSPEND_MASK)});
          chk("R5 busy done", {31'd0, busy}, 32'd0);
          chk("R9 suspend ignored", {31'd0, pll_en}, 32'd1);
        end
      end
    end

    // R10 simultaneous requests, suspend wins; write in accept cycle dropped
    wr(SEL_GATE, 32'h0000_0100);
    @(negedge clk);
    sus_req = 1'b1; res_req = 1'b1;
    wr_en = 1'b1; wr_sel = SEL_GATE; wr_data = 32'h0000_8000;
    @(negedge clk);
    sus_req = 1'b0; res_req = 1'b0; wr_en = 1'b0;
    rd(SEL_GATE, d);
    chk("R10 suspend wins mask", d, 32'h0000_1103);
    @(negedge clk);
    chk("R10 suspend wins pll off", {31'd0, pll_en}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule